// File: doc/BRIEF.md
# Dual-Read Single-Write Register File with Index Seeding

This block is the general-purpose register store of a small load/store core. It has 32 entries of 8 bits each. Two read ports and one write port all work in the same clock cycle. The block takes the 32-bit instruction word and pulls both source indices out of it directly. The destination index comes from one of two instruction fields, and the core picks which one with a select input: the three-register form uses one field, the immediate form uses the other.

A synchronous reset seeds every entry with its own index, so entry 5 holds 5 and entry 31 holds 31. Test programs can then run without first loading constants. Entry 0 is wired to zero. The read ports are combinational and show the contents stored before the clock edge. A write in the current cycle becomes visible only on the next cycle; there is no forwarding.

Top module: `regfile_2r1w`

## Requirements
- R1: The file holds 32 entries of 8 bits, and every entry can be written and read back independently of the others.
- R2: Both read ports are combinational and independent. A port reading the entry that is being written in the same cycle shows the value stored before that cycle's clock edge.
- R3: Read port A is addressed by instruction bits [25:21] and read port B by bits [20:16]. The other instruction bits do not affect the reads.
- R4: The write index is instruction bits [15:11] when `dst_is_rt` is 0, and bits [20:16] when `dst_is_rt` is 1.
- R5: A write takes effect on the rising clock edge when `wr_en` is 1. When `wr_en` is 0, no entry changes.
- R6: While `rst` is 1 at a rising edge, entry n is loaded with the value n, for every n from 0 to 31.
- R7: Entry 0 always reads as zero. Writes that target index 0 have no effect.
- R8: Reset is synchronous and active high, and it overrides a write requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset that seeds the entries |
| instr | input | 32 | Instruction word supplying the source and destination indices |
| dst_is_rt | input | 1 | Destination field select: 0 selects bits [15:11], 1 selects bits [20:16] |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Data to write |
| rd_data_a | output | 8 | Contents of the entry indexed by bits [25:21] |
| rd_data_b | output | 8 | Contents of the entry indexed by bits [20:16] |

## Verification
A read of the entry being written in the same cycle must return the old value. A design that forwarded the new data would fail this on the first such cycle. Writes to index 0 through either destination field must leave zero on both ports, because a file that stored entry 0 would return the written byte. Reset is asserted together with a pending write, and every entry's seed is then read back. This catches a reset that clears to zero, loses its priority over the write, or seeds an entry with the wrong value. The bench also sets the opcode and low instruction bits to ones, and flips the destination select while keeping the fields different. A wrong bit slice or a swapped field select then writes to, or reads from, the wrong entry.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int INSTR_W   = 32;
    localparam int IDX_W     = 5;
    localparam int ENTRIES   = 1 << IDX_W;
    localparam int WORD_W    = 8;

    // Field positions inside the instruction word
    localparam int SRC_A_LSB = 21;
    localparam int SRC_B_LSB = 16;
    localparam int DST_LSB   = 11;

    typedef logic [IDX_W-1:0]   reg_idx_t;
    typedef logic [WORD_W-1:0]  reg_word_t;
    typedef logic [INSTR_W-1:0] instr_t;

    typedef enum logic {
        DST_FROM_RD = 1'b0,
        DST_FROM_RT = 1'b1
    } dst_sel_e;

    typedef struct packed {
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
    } reg_fields_t;

    typedef struct packed {
        logic      en;
        reg_idx_t  idx;
        reg_word_t data;
    } wr_req_t;

    function automatic reg_idx_t slice_idx(instr_t word, int lsb);
        return reg_idx_t'(word >> lsb);
    endfunction

endpackage

// File: rtl/rf_field_decode.sv
module rf_field_decode
    import regfile_pkg::*;
(
    input  instr_t      instr,
    input  dst_sel_e    dst_sel,
    output reg_fields_t fields
);

    reg_idx_t rd_field;
    reg_idx_t rt_field;

    always_comb begin
        rd_field     = slice_idx(instr, DST_LSB);
        rt_field     = slice_idx(instr, SRC_B_LSB);
        fields.src_a = slice_idx(instr, SRC_A_LSB);
        fields.src_b = rt_field;
        fields.dst   = (dst_sel == DST_FROM_RT) ? rt_field : rd_field;
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int NUM_ENTRIES = 32,
    parameter int DATA_W      = 8,
    localparam int ADDR_W     = $clog2(NUM_ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   waddr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [NUM_ENTRIES-1:0][DATA_W-1:0]  cells
);

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_entry
            if (g == 0) begin : g_zero
                assign cells[g] = '0;
            end else begin : g_live
                logic [DATA_W-1:0] value_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        value_q <= DATA_W'(g);
                    end else if (we && (waddr == ADDR_W'(g))) begin
                        value_q <= wdata;
                    end
                end
                assign cells[g] = value_q;
            end
        end
    endgenerate

endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
    parameter int NUM_ENTRIES = 32,
    parameter int DATA_W      = 8,
    localparam int ADDR_W     = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0][DATA_W-1:0] cells,
    input  logic [ADDR_W-1:0]                  raddr,
    output logic [DATA_W-1:0]                  rdata
);

    always_comb begin
        rdata = cells[raddr];
    end

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic              dst_is_rt,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data_a,
    output logic [WORD_W-1:0] rd_data_b
);

    localparam int READ_PORTS = 2;

    reg_fields_t                        fields;
    wr_req_t                            wreq;
    reg_idx_t                           wr_idx;
    logic [ENTRIES-1:0][WORD_W-1:0]     cells;
    logic [READ_PORTS-1:0][IDX_W-1:0]   port_addr;
    logic [READ_PORTS-1:0][WORD_W-1:0]  port_data;

    rf_field_decode u_decode (
        .instr   (instr),
        .dst_sel (dst_sel_e'(dst_is_rt)),
        .fields  (fields)
    );

    always_comb begin
        wreq.en   = wr_en;
        wreq.idx  = fields.dst;
        wreq.data = wr_data;
    end

    assign wr_idx = wreq.idx;

    rf_storage #(
        .NUM_ENTRIES (ENTRIES),
        .DATA_W      (WORD_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wreq.en),
        .waddr (wreq.idx),
        .wdata (wreq.data),
        .cells (cells)
    );

    assign port_addr[0] = fields.src_a;
    assign port_addr[1] = fields.src_b;

    genvar p;
    generate
        for (p = 0; p < READ_PORTS; p++) begin : g_rport
            rf_read_mux #(
                .NUM_ENTRIES (ENTRIES),
                .DATA_W      (WORD_W)
            ) u_mux (
                .cells (cells),
                .raddr (port_addr[p]),
                .rdata (port_data[p])
            );
        end
    endgenerate

    assign rd_data_a = port_data[0];
    assign rd_data_b = port_data[1];

endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk
    import regfile_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr,
    input logic               wr_en,
    input logic [WORD_W-1:0]  wr_data,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [WORD_W-1:0]  rd_data_a,
    input logic [WORD_W-1:0]  rd_data_b
);

    reg_idx_t a_idx;
    reg_idx_t b_idx;
    assign a_idx = slice_idx(instr, SRC_A_LSB);
    assign b_idx = slice_idx(instr, SRC_B_LSB);

    // R7: entry zero reads as zero on either port
    p_zero_port_a_r7: assert property (@(posedge clk) disable iff (rst)
        (a_idx == '0) |-> (rd_data_a == '0));
    p_zero_port_b_r7: assert property (@(posedge clk) disable iff (rst)
        (b_idx == '0) |-> (rd_data_b == '0));

    // R6/R8: the cycle after reset, each port shows the seed of its index
    p_seed_port_a_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_a == WORD_W'(a_idx)));
    p_seed_port_b_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_b == WORD_W'(b_idx)));

    // R5: an enabled write to a nonzero index is visible next cycle
    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx != '0)) |=>
            ((a_idx != $past(wr_idx)) || (rd_data_a == $past(wr_data))));

    // R5: without a write and with a steady instruction, reads hold
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!$stable(instr) || ($stable(rd_data_a) && $stable(rd_data_b))));

endmodule

bind regfile_2r1w regfile_2r1w_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_idx    (wr_idx),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/test_regfile_2r1w.sv
module test_regfile_2r1w;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        dst_is_rt = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data_a;
    logic [7:0]  rd_data_b;

    int vectors = 0;
    int misses  = 0;
    logic [7:0] model [32];
    bit model_valid = 0;

    always #2 clk = ~clk;   // 250 MHz

    regfile_2r1w i_regfile_2r1w (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .dst_is_rt (dst_is_rt),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    function automatic logic [31:0] mk(int a, int b, int d, logic [5:0] top, logic [10:0] low);
        return {top, 5'(a), 5'(b), 5'(d), low};
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare combinational reads against the model, then
    // advance the model across the rising edge.
    task automatic step(logic r, logic [31:0] ins, logic sel, logic we,
                        logic [7:0] wd, string tag);
        @(negedge clk);
        rst = r; instr = ins; dst_is_rt = sel; wr_en = we; wr_data = wd;
        #1;
        if (model_valid) begin
            check(tag, "port A", rd_data_a, model[ins[25:21]]);
            check(tag, "port B", rd_data_b, model[ins[20:16]]);
        end
        @(posedge clk);
        if (r) begin
            for (int n = 0; n < 32; n++) model[n] = 8'(n);
            model_valid = 1;
        end else if (we) begin
            int d;
            d = sel ? int'(ins[20:16]) : int'(ins[15:11]);
            if (d != 0) model[d] = wd;
        end
    endtask

    initial begin
        #400000;
        misses++;
        $display("FAIL watchdog: actual still running, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R8: reset asserted with a pending write to entry 5
        step(1, mk(5, 5, 5, 6'h0, 11'h0), 1'b0, 1'b1, 8'hEE, "R8");
        step(1, mk(5, 5, 5, 6'h0, 11'h0), 1'b0, 1'b1, 8'hEE, "R8");
        step(0, mk(5, 6, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R8");

        // R6: every entry holds its index after reset
        for (int i = 0; i < 32; i++)
            step(0, mk(i, 31 - i, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R6");

        // R2: write each entry while reading it; old value must show
        for (int i = 1; i < 32; i++)
            step(0, mk(i, i, i, 6'h0, 11'h0), 1'b0, 1'b1, 8'(i * 9 + 100), "R2");
        // R1: read all written values back
        for (int i = 0; i < 32; i++)
            step(0, mk(i, (i + 7) % 32, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R1");

        // R4: destination taken from bits [20:16] when selected
        step(0, mk(3, 7, 9, 6'h0, 11'h0), 1'b1, 1'b1, 8'hA5, "R4");
        step(0, mk(7, 9, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R4");
        step(0, mk(3, 11, 12, 6'h0, 11'h0), 1'b0, 1'b1, 8'h3C, "R4");
        step(0, mk(12, 11, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R4");

        // R5: disabled write leaves the file unchanged
        step(0, mk(4, 8, 4, 6'h0, 11'h0), 1'b0, 1'b0, 8'h55, "R5");
        step(0, mk(4, 8, 8, 6'h0, 11'h0), 1'b1, 1'b0, 8'h66, "R5");
        step(0, mk(4, 8, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R5");

        // R7: writes to entry 0 through either field are dropped
        step(0, mk(0, 0, 0, 6'h0, 11'h0), 1'b0, 1'b1, 8'hFF, "R7");
        step(0, mk(0, 0, 0, 6'h0, 11'h0), 1'b1, 1'b1, 8'h81, "R7");
        step(0, mk(0, 0, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R7");

        // R3: opcode and low bits set must not disturb the indices
        step(0, mk(13, 14, 15, 6'h3F, 11'h7FF), 1'b0, 1'b1, 8'h5A, "R3");
        step(0, mk(15, 13, 2, 6'h3F, 11'h7FF), 1'b0, 1'b0, 8'h00, "R3");

        // R1: mixed traffic
        for (int k = 0; k < 400; k++)
            step(0, $urandom(), 1'($urandom()), 1'($urandom()), 8'($urandom()), "R1");

        // R8 again mid-run, then R6 seeds everywhere
        step(1, mk(20, 21, 20, 6'h0, 11'h0), 1'b0, 1'b1, 8'h77, "R8");
        for (int i = 0; i < 32; i++)
            step(0, mk(i, 31 - i, 0, 6'h0, 11'h0), 1'b0, 1'b0, 8'h00, "R6");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule